// File: doc/BRIEF.md
# Write-Only Key Holding Register Bank

This block holds the secret keys used by two symmetric engines: slot 0 feeds the hash/MAC unit and slot 1 feeds the block cipher unit. Software fills a slot one 32-bit word at a time over a simple register bus. No bus read can ever return key material. Only one initiator, identified by a parameterised ID, may change the bank. Writes from any other initiator are refused with an error response.

A second path loads a whole 128-bit or 256-bit key in a single transfer from an on-chip secure key store. That path is a valid/ready stream. Its contents never appear on the register bus. The bus has priority. `ld_ready` is low in every cycle where an authorised bus write is presented, and at all other times it is high. The store may hold `ld_valid` and its payload steady until it sees `ld_ready`. The transfer happens on a clock edge where both `ld_valid` and `ld_ready` are high.

Each slot drives its key on a dedicated engine port, together with a key-valid flag and a size flag. While a slot is not valid, its key port shows all zeros. A zeroize command clears both slots in one cycle.

Top module: `wo_key_bank`

## Requirements
- R1: After reset, both key ports are zero, both valid flags are 0 and both size flags are 0 (128-bit).
- R2: A read (`bus_we`=0) from any initiator at any address returns `bus_rdata`=0 with `bus_rsp_err`=0 and changes no slot.
- R3: A write whose `bus_id` differs from `AUTH_ID` is answered with `bus_rsp_err`=1 and leaves every key, valid flag and size flag unchanged.
- R4: Word addresses 0..7 select MAC-slot words 0..7 and addresses 8..15 select cipher-slot words 0..7. Word i occupies key bits [32i+31:32i]. A slot becomes valid only once every word it needs has been written since its last restart: words 0..3 for a 128-bit key, words 0..7 for a 256-bit key. Until then its key port reads zero.
- R5: A write to address 16 (MAC slot) or 17 (cipher slot) sets that slot's size from `bus_wdata[0]` (1 = 256-bit), clears its key and drops its valid flag.
- R6: A word write to a slot that is currently valid starts a new key. All previously held words are discarded, the valid flag drops, and only the new word is retained.
- R7: A write to word 4..7 of a slot set to 128 bits, or to any address above 18, gets `bus_rsp_err`=1 and changes nothing.
- R8: A write to address 18 with `bus_wdata[0]`=1 clears both keys, drops both valid flags and returns both sizes to 128 bits on the next cycle. With `bus_wdata[0]`=0 it has no effect and no error.
- R9: A store transfer loads slot `ld_slot` (0 = MAC, 1 = cipher) with `ld_key` and sets its size from `ld_256`. A 128-bit load keeps bits [127:0] and zeroes bits [255:128]. The slot is valid on the next cycle.
- R10: `ld_ready` is 0 in exactly the cycles where an authorised write is presented. A held `ld_valid` is taken on the first cycle that `ld_ready` returns to 1, and exactly once.
- R11: Every bus request is answered by `bus_rsp_valid`=1 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_id | input | ID_W | Initiator identifier |
| bus_rsp_valid | output | 1 | Response strobe, one cycle after request |
| bus_rsp_err | output | 1 | Error response |
| bus_rdata | output | 32 | Read data, always zero |
| ld_valid | input | 1 | Store load offered |
| ld_ready | output | 1 | Store load accepted this cycle |
| ld_slot | input | 1 | Target slot of store load |
| ld_256 | input | 1 | Store load is 256-bit |
| ld_key | input | 256 | Store key payload |
| mac_key | output | 256 | Key to MAC unit, zero unless valid |
| mac_key_valid | output | 1 | MAC key complete |
| mac_key_256 | output | 1 | MAC key size is 256 |
| aes_key | output | 256 | Key to cipher unit, zero unless valid |
| aes_key_valid | output | 1 | Cipher key complete |
| aes_key_256 | output | 1 | Cipher key size is 256 |

## Verification
Several properties are checked on every clock cycle:
- the one-cycle response timing;
- the error flag and frozen key ports after foreign writes;
- the wipe after zeroize;
- valid being set after a store transfer;
- the zeroed upper half of short keys;
- the valid drop on reconfiguration or restart.

Other behaviours only appear through the bench's scenarios. These are:
- the exact word-to-bit placement;
- valid appearing on the final word and not before;
- out-of-range word rejection;
- the cycles where a held store transfer waits behind bus writes.

// File: rtl/wkb_pkg.sv
package wkb_pkg;
  parameter int WORD_W = 32;
  parameter int KEY_W  = 256;
  parameter int NSLOT  = 2;
  localparam int SLOT_MAC = 0;
  localparam int SLOT_AES = 1;
  localparam int WORDS    = KEY_W / WORD_W;
  localparam int HALF     = WORDS / 2;
  localparam int IDX_W    = $clog2(WORDS);
  localparam int SLOT_W   = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [KEY_W-1:0]  key_t;
endpackage

// File: rtl/wkb_bus_decode.sv
module wkb_bus_decode
  import wkb_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int ID_W    = 4,
  parameter int AUTH_ID = 3
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [NSLOT-1:0]  slot_256_i,
  output logic [NSLOT-1:0]  word_we_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic [NSLOT-1:0]  cfg_we_o,
  output logic              cfg_256_o,
  output logic              zero_o,
  output logic              err_o,
  output logic              auth_wr_o
);
  localparam int WRGN   = NSLOT * WORDS;
  localparam int CFG_B  = WRGN;
  localparam int ZADDR  = WRGN + NSLOT;

  logic wr, auth, cfg_hit;

  assign wr         = req_i && we_i;
  assign auth       = (id_i == ID_W'(AUTH_ID));
  assign auth_wr_o  = wr && auth;
  assign word_idx_o = addr_i[IDX_W-1:0];
  assign cfg_256_o  = wdata_i[0];

  always_comb begin
    word_we_o = '0;
    cfg_we_o  = '0;
    zero_o    = 1'b0;
    err_o     = 1'b0;
    cfg_hit   = 1'b0;
    if (wr && !auth) begin
      err_o = 1'b1;
    end else if (wr) begin
      if (addr_i < ADDR_W'(WRGN)) begin
        for (int s = 0; s < NSLOT; s++) begin
          if (addr_i[IDX_W +: SLOT_W] == SLOT_W'(s)) begin
            if (!slot_256_i[s] && addr_i[IDX_W-1]) err_o = 1'b1;
            else word_we_o[s] = 1'b1;
          end
        end
      end else if (addr_i == ADDR_W'(ZADDR)) begin
        zero_o = wdata_i[0];
      end else begin
        for (int s = 0; s < NSLOT; s++) begin
          if (addr_i == ADDR_W'(CFG_B + s)) begin
            cfg_we_o[s] = 1'b1;
            cfg_hit     = 1'b1;
          end
        end
        if (!cfg_hit) err_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wkb_key_slot.sv
module wkb_key_slot
  import wkb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero_i,
  input  logic             cfg_we_i,
  input  logic             cfg_256_i,
  input  logic             word_we_i,
  input  logic [IDX_W-1:0] word_idx_i,
  input  word_t            word_i,
  input  logic             ld_we_i,
  input  logic             ld_256_i,
  input  key_t             ld_key_i,
  output key_t             key_o,
  output logic             valid_o,
  output logic             is256_o
);
  key_t             key_q, wr_key;
  logic [WORDS-1:0] mask_q, wr_mask, need;
  logic             valid_q, big_q;

  assign need = big_q ? {WORDS{1'b1}} : {{(WORDS-HALF){1'b0}}, {HALF{1'b1}}};

  always_comb begin
    wr_key  = valid_q ? '0 : key_q;
    wr_mask = valid_q ? '0 : mask_q;
    wr_key[word_idx_i*WORD_W +: WORD_W] = word_i;
    wr_mask = wr_mask | (WORDS'(1) << word_idx_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      mask_q  <= '0;
      valid_q <= 1'b0;
      big_q   <= 1'b0;
    end else if (zero_i) begin
      key_q   <= '0;
      mask_q  <= '0;
      valid_q <= 1'b0;
      big_q   <= 1'b0;
    end else if (ld_we_i) begin
      key_q   <= ld_256_i ? ld_key_i : {{(KEY_W/2){1'b0}}, ld_key_i[KEY_W/2-1:0]};
      mask_q  <= '1;
      valid_q <= 1'b1;
      big_q   <= ld_256_i;
    end else if (cfg_we_i) begin
      key_q   <= '0;
      mask_q  <= '0;
      valid_q <= 1'b0;
      big_q   <= cfg_256_i;
    end else if (word_we_i) begin
      key_q   <= wr_key;
      mask_q  <= wr_mask;
      valid_q <= ((wr_mask & need) == need);
    end
  end

  assign key_o   = valid_q ? key_q : '0;
  assign valid_o = valid_q;
  assign is256_o = big_q;

  AST_ZERO_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    zero_i |=> (key_q == '0 && !valid_q && !big_q)); // R8
  AST_LOAD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we_i && !zero_i) |=> valid_q); // R9
  AST_SHORT_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !big_q) |-> key_q[KEY_W-1:KEY_W/2] == '0); // R9
  AST_CFG_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !zero_i && !ld_we_i) |=> !valid_q); // R5
  AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && word_we_i && !zero_i && !ld_we_i && !cfg_we_i) |=> !valid_q); // R6
endmodule

// File: rtl/wo_key_bank.sv
module wo_key_bank
  import wkb_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int ID_W    = 4,
  parameter int AUTH_ID = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [ID_W-1:0]   bus_id,
  output logic              bus_rsp_valid,
  output logic              bus_rsp_err,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_slot,
  input  logic              ld_256,
  input  logic [KEY_W-1:0]  ld_key,
  output logic [KEY_W-1:0]  mac_key,
  output logic              mac_key_valid,
  output logic              mac_key_256,
  output logic [KEY_W-1:0]  aes_key,
  output logic              aes_key_valid,
  output logic              aes_key_256
);
  logic [NSLOT-1:0] word_we, cfg_we, slot_256, slot_valid, ld_we;
  logic [IDX_W-1:0] word_idx;
  logic             cfg_256, zero, err, auth_wr, ld_fire;
  key_t             slot_key [NSLOT];
  logic             rsp_v_q, rsp_e_q;

  wkb_bus_decode #(.ADDR_W(ADDR_W), .ID_W(ID_W), .AUTH_ID(AUTH_ID)) u_dec (
    .req_i(bus_req), .we_i(bus_we), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .id_i(bus_id), .slot_256_i(slot_256), .word_we_o(word_we),
    .word_idx_o(word_idx), .cfg_we_o(cfg_we), .cfg_256_o(cfg_256),
    .zero_o(zero), .err_o(err), .auth_wr_o(auth_wr)
  );

  assign ld_ready = !auth_wr;
  assign ld_fire  = ld_valid && ld_ready;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign ld_we[s] = ld_fire && (ld_slot == SLOT_W'(s));
    wkb_key_slot u_slot (
      .clk(clk), .rst_n(rst_n), .zero_i(zero),
      .cfg_we_i(cfg_we[s]), .cfg_256_i(cfg_256),
      .word_we_i(word_we[s]), .word_idx_i(word_idx), .word_i(bus_wdata),
      .ld_we_i(ld_we[s]), .ld_256_i(ld_256), .ld_key_i(ld_key),
      .key_o(slot_key[s]), .valid_o(slot_valid[s]), .is256_o(slot_256[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_e_q <= 1'b0;
    end else begin
      rsp_v_q <= bus_req;
      rsp_e_q <= bus_req && err;
    end
  end

  assign bus_rsp_valid = rsp_v_q;
  assign bus_rsp_err   = rsp_e_q;
  assign bus_rdata     = '0;

  assign mac_key       = slot_key[SLOT_MAC];
  assign mac_key_valid = slot_valid[SLOT_MAC];
  assign mac_key_256   = slot_256[SLOT_MAC];
  assign aes_key       = slot_key[SLOT_AES];
  assign aes_key_valid = slot_valid[SLOT_AES];
  assign aes_key_256   = slot_256[SLOT_AES];

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_rsp_valid); // R11
  AST_FOREIGN_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_id != ID_W'(AUTH_ID)) |=> bus_rsp_err); // R3
  AST_FOREIGN_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_id != ID_W'(AUTH_ID) && !ld_valid)
      |=> ($stable(mac_key) && $stable(aes_key) && $stable(mac_key_valid)
           && $stable(aes_key_valid) && $stable(mac_key_256) && $stable(aes_key_256))); // R3
  AST_READ_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> !bus_rsp_err); // R2
endmodule

// File: tb/wo_key_bank_tb.sv
module wo_key_bank_tb;
  localparam int AUTH = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 0, bus_we = 0, ld_valid = 0, ld_slot = 0, ld_256 = 0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0] bus_id = '0;
  logic [255:0] ld_key = '0;
  logic bus_rsp_valid, bus_rsp_err, ld_ready;
  logic [31:0] bus_rdata;
  logic [255:0] mac_key, aes_key;
  logic mac_key_valid, mac_key_256, aes_key_valid, aes_key_256;

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";

  wo_key_bank #(.ADDR_W(6), .ID_W(4), .AUTH_ID(AUTH)) u_dut (.*);

  always #10 clk = ~clk;

  // behavioural reference model
  logic [31:0] mk [2][8];
  logic [7:0]  msk [2];
  logic        mval [2], mbig [2];
  logic        ex_rv = 0, ex_re = 0;
  initial for (int s = 0; s < 2; s++) begin
    msk[s] = 0; mval[s] = 0; mbig[s] = 0;
    for (int i = 0; i < 8; i++) mk[s][i] = 0;
  end

  function automatic void clear_slot(int s);
    for (int i = 0; i < 8; i++) mk[s][i] = 0;
    msk[s] = 0; mval[s] = 0;
  endfunction

  function automatic logic [255:0] exkey(int s);
    logic [255:0] k = '0;
    if (mval[s]) for (int i = 0; i < 8; i++) k[32*i +: 32] = mk[s][i];
    return k;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin clear_slot(s); mbig[s] = 0; end
      ex_rv = 0; ex_re = 0;
    end else begin
      automatic logic aw = bus_req && bus_we && bus_id == AUTH;
      automatic logic fire = ld_valid && !aw;
      automatic logic e = 0;
      if (bus_req && bus_we && bus_id != AUTH) e = 1;
      else if (aw) begin
        if (bus_addr < 16) begin
          automatic int s = bus_addr / 8;
          automatic int i = bus_addr % 8;
          if (!mbig[s] && i >= 4) e = 1;
          else begin
            if (mval[s]) clear_slot(s);
            mk[s][i] = bus_wdata;
            msk[s][i] = 1'b1;
            mval[s] = mbig[s] ? (msk[s] == 8'hff) : (msk[s][3:0] == 4'hf);
          end
        end else if (bus_addr == 16 || bus_addr == 17) begin
          clear_slot(bus_addr - 16); mbig[bus_addr - 16] = bus_wdata[0];
        end else if (bus_addr == 18) begin
          if (bus_wdata[0]) for (int s = 0; s < 2; s++) begin clear_slot(s); mbig[s] = 0; end
        end else e = 1;
      end
      if (fire) begin
        for (int i = 0; i < 8; i++) mk[ld_slot][i] = (i < 4 || ld_256) ? ld_key[32*i +: 32] : 32'h0;
        msk[ld_slot] = 8'hff; mval[ld_slot] = 1; mbig[ld_slot] = ld_256;
      end
      ex_rv = bus_req; ex_re = bus_req && e;
    end
  end

  task automatic chk(input logic ok, input string what, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    automatic logic exp_rdy = !(bus_req && bus_we && bus_id == AUTH);
    chk(mac_key == exkey(0), "mac_key", mac_key, exkey(0));
    chk(aes_key == exkey(1), "aes_key", aes_key, exkey(1));
    chk({mac_key_valid, mac_key_256, aes_key_valid, aes_key_256} == {mval[0], mbig[0], mval[1], mbig[1]},
        "flags", {mac_key_valid, mac_key_256, aes_key_valid, aes_key_256},
        {mval[0], mbig[0], mval[1], mbig[1]});
    chk({bus_rsp_valid, bus_rsp_err} == {ex_rv, ex_re}, "rsp", {bus_rsp_valid, bus_rsp_err}, {ex_rv, ex_re});
    chk(bus_rdata == 0, "rdata R2", bus_rdata, 0);
    chk(ld_ready == exp_rdy, "ld_ready R10", ld_ready, exp_rdy);
  end

  task automatic bus(input logic we, input logic [3:0] id, input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_req = 1; bus_we = we; bus_id = id; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic load(input logic s, input logic big, input logic [255:0] k);
    logic fired;
    @(posedge clk); #2;
    ld_valid = 1; ld_slot = s; ld_256 = big; ld_key = k;
    do begin @(negedge clk); fired = ld_ready; @(posedge clk); end while (!fired);
    #2 ld_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk(!mac_key_valid && !aes_key_valid && mac_key == 0 && aes_key == 0, "reset R1",
        {mac_key_valid, aes_key_valid}, 0);
    @(posedge clk); #2 rst_n = 1;

    cur_req = "R4";
    for (int i = 0; i < 4; i++) begin
      bus(1, AUTH, 6'(i), 32'hA0A0_0000 + i);
      @(negedge clk);
      chk(mac_key_valid == (i == 3), "R4 valid on last word", mac_key_valid, (i == 3));
    end
    chk(mac_key[127:96] == 32'hA0A0_0003, "R4 word3 position", mac_key[127:96], 32'hA0A0_0003);

    cur_req = "R2";
    bus(0, AUTH, 0, 0); @(negedge clk);
    chk(bus_rsp_valid && !bus_rsp_err && bus_rdata == 0, "R2 read zero", bus_rdata, 0);
    bus(0, 4'h7, 9, 0);

    cur_req = "R5";
    bus(1, AUTH, 17, 1);
    for (int i = 0; i < 7; i++) bus(1, AUTH, 6'(8 + i), 32'hC0DE_0000 + i);
    @(negedge clk);
    chk(!aes_key_valid, "R5 seven of eight words", aes_key_valid, 0);
    bus(1, AUTH, 15, 32'hC0DE_0007); @(negedge clk);
    chk(aes_key_valid && aes_key[255:224] == 32'hC0DE_0007, "R5 256-bit complete", aes_key[255:224], 32'hC0DE_0007);

    cur_req = "R6";
    bus(1, AUTH, 2, 32'h1234_5678); @(negedge clk);
    chk(!mac_key_valid && mac_key == 0, "R6 restart drops", mac_key_valid, 0);

    cur_req = "R7";
    bus(1, AUTH, 5, 32'hDEAD); @(negedge clk);
    chk(bus_rsp_err, "R7 word beyond size", bus_rsp_err, 1);
    bus(1, AUTH, 30, 1); @(negedge clk);
    chk(bus_rsp_err, "R7 unmapped", bus_rsp_err, 1);

    cur_req = "R3";
    bus(1, 4'h1, 18, 1); @(negedge clk);
    chk(bus_rsp_err && aes_key_valid, "R3 foreign zeroize ignored", {bus_rsp_err, aes_key_valid}, 2'b11);
    bus(1, 4'h0, 8, 32'hBAD); @(negedge clk);
    chk(aes_key[31:0] == 32'hC0DE_0000, "R3 foreign word ignored", aes_key[31:0], 32'hC0DE_0000);

    cur_req = "R9";
    load(1, 0, {8{32'h5555_AAAA}}); @(negedge clk);
    chk(aes_key_valid && !aes_key_256 && aes_key[255:128] == 0, "R9 short load", aes_key[255:128], 0);
    load(0, 1, {8{32'h0F0F_1E1E}}); @(negedge clk);
    chk(mac_key == {8{32'h0F0F_1E1E}}, "R9 long load", mac_key, {8{32'h0F0F_1E1E}});

    cur_req = "R10";
    fork
      load(1, 1, {8{32'h7777_8888}});
      begin bus(1, AUTH, 16, 0); bus(1, AUTH, 16, 1); end
    join
    @(negedge clk);
    chk(aes_key == {8{32'h7777_8888}}, "R10 held load lands", aes_key, {8{32'h7777_8888}});

    cur_req = "R11";
    bus(0, 4'h9, 3, 0); @(negedge clk);
    chk(bus_rsp_valid, "R11 response", bus_rsp_valid, 1);

    cur_req = "R8";
    bus(1, AUTH, 18, 0); @(negedge clk);
    chk(aes_key_valid && !bus_rsp_err, "R8 bit0 clear no effect", aes_key_valid, 1);
    bus(1, AUTH, 18, 1); @(negedge clk);
    chk(!aes_key_valid && !mac_key_valid && !aes_key_256 && !mac_key_256 && aes_key == 0,
        "R8 zeroize", {aes_key_valid, mac_key_valid, aes_key_256, mac_key_256}, 0);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog %s act=%0d exp=<20000", cur_req, cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule